// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Controller

This block moves data between I/O devices and memory without the data ever entering it. Four channels, 0 to 3, are each programmed with a start address, a transfer count and a mode. When a device raises its request, the controller first asks the processor for the bus and waits for the grant. Once it holds the bus, it drives the memory address, the acknowledge of the chosen channel and a matched pair of strobes: one for the I/O side and one for the memory side. The device and the memory then exchange the data word directly on the shared data lines.

Only one channel is served at a time. Channel choice follows a fixed order or a rotating order, selected by a command bit. A channel can release the bus after every word, hold it for the whole block, or keep going for as long as its device keeps requesting. When the count runs out, the channel records terminal count in a status register. It then either reloads its programmed values or masks itself.

Software reaches all of this through a small 16-entry register window. The same window lets software read back each channel's current address and count.

Top module: `dma4_flyby`

## Requirements
- R1: After reset all four mask bits are set, the command register and the terminal-count status bits are zero, `bus_req` is low and no acknowledge is active.
- R2: No transfer starts until `bus_req` has been raised and `bus_grant` has been seen high; while the grant is withheld, `bus_req` stays high and no acknowledge appears.
- R3: At most one channel acknowledge is active in any cycle.
- R4: Mode bits [1:0] select the transfer type:
  - 01 (write to memory) asserts `io_rd` with `mem_wr`.
  - 10 (read from memory) asserts `mem_rd` with `io_wr`.
  - 00 (verify) drives the address and the acknowledge with no strobes.
  - The block never asserts both strobes of one side together.
- R5: Each transfer steps the current address by one (up when mode bit 3 is 0, down when it is 1) and lowers the current count by one. A channel programmed with count N makes N+1 transfers, and `tc_end` marks the last of them.
- R6: At terminal count the channel's status bit (bit n for channel n) is set. With mode bit 2 set, the current address and count reload from the programmed values and the mask is untouched. Otherwise the channel's mask bit is set.
- R7: Mode bits [5:4] select how long the bus is held:
  - 01 (single) releases the bus after every transfer.
  - 10 (block) keeps it until terminal count, even if the request drops.
  - 00 (demand) keeps it while the request is still active at the end of each transfer.
- R8: With command bit 1 clear, the lowest-numbered eligible channel wins. With it set, the search starts just after the channel served last, so that channel has lowest priority.
- R9: Command bit 2 makes the request inputs active low. Command bit 3 makes the acknowledge outputs active low, so they idle high.
- R10: Command bit 0 set disables the controller: pending requests raise no bus request.
- R11: Mask writes and masked channels behave as follows:
  - A write to address 13 sets (data bit 2 = 1) or clears (data bit 2 = 0) the mask of the channel in data bits [1:0].
  - A write to address 14 loads all four mask bits from data bits [3:0].
  - A masked channel is never serviced.
- R12: Address 15 reads the status register:
  - Bits [3:0] hold the latched terminal-count flags.
  - Bits [7:4] hold the active request of each channel after polarity.
  - A read clears the terminal-count flags.
- R13: Register window layout:
  - Addresses 0–3 write a channel's start address (programmed and current value) and read its current address.
  - Addresses 4–7 do the same for the count.
  - Addresses 8–11 hold the 6-bit modes.
  - Address 12 holds the 4-bit command.
  - Address 14 reads back the mask bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status flags on address 15) |
| reg_addr | input | 4 | Register window address |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data (combinational) |
| dev_req | input | 4 | Per-channel device request, polarity per command bit 2 |
| dev_ack | output | 4 | Per-channel acknowledge, polarity per command bit 3 |
| bus_req | output | 1 | Bus request to the processor |
| bus_grant | input | 1 | Bus grant from the processor |
| mem_addr | output | W | Memory address of the current transfer |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| tc_end | output | 1 | Marks the transfer that reaches terminal count |

## Verification
The hardest case to reach from the ports is a demand-mode channel that stops partway through its count. The request has to drop in exactly the cycle of a chosen transfer, so that the controller sees it inactive at the end of that transfer.

The bench handles this with a level-sensitive wait on the monitor's transfer counter. The wait releases the request in the same time step in which the monitor counts the Nth acknowledge, which is one half-clock before the deciding edge. The bench then reads the channel's current address and count back through the register window to confirm the exact stopping point.

Rotating priority is reached by running two single-mode channels against each other. The order in which the scoreboard expects their transfers then exposes any slip in the rotation.

// File: rtl/dma4_flyby.sv
module dma4_flyby #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [3:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [3:0]   dev_req,
  output logic [3:0]   dev_ack,
  output logic         bus_req,
  input  logic         bus_grant,
  output logic [W-1:0] mem_addr,
  output logic         mem_rd,
  output logic         mem_wr,
  output logic         io_rd,
  output logic         io_wr,
  output logic         tc_end
);
  localparam int NCH = 4;

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_XFER} st_t;
  st_t st;

  logic [W-1:0] base_a [NCH];
  logic [W-1:0] base_c [NCH];
  logic [W-1:0] cur_a  [NCH];
  logic [W-1:0] cur_c  [NCH];
  logic [5:0]   mode   [NCH];
  logic [3:0]   cmd, mask, tc_st;
  logic [1:0]   act, last, start, pick, idx;
  logic         found;

  logic [3:0] req_act, elig, ack_hot;
  logic       xfer, is_tc, cont;
  logic [1:0] typ, span;

  assign req_act = dev_req ^ {NCH{cmd[2]}};
  assign elig    = req_act & ~mask & {NCH{~cmd[0]}};
  assign start   = cmd[1] ? last + 2'd1 : 2'd0;

  always_comb begin
    pick  = start;
    found = 1'b0;
    idx   = start;
    for (int i = 0; i < NCH; i++) begin
      idx = start + 2'(i);
      if (!found && elig[idx]) begin
        pick  = idx;
        found = 1'b1;
      end
    end
  end

  assign xfer  = (st == S_XFER);
  assign typ   = mode[act][1:0];
  assign span  = mode[act][5:4];
  assign is_tc = (cur_c[act] == '0);
  assign cont  = !is_tc && (span == 2'b10 || (span == 2'b00 && req_act[act]));

  assign ack_hot  = xfer ? (4'b0001 << act) : 4'b0000;
  assign dev_ack  = ack_hot ^ {NCH{cmd[3]}};
  assign bus_req  = (st != S_IDLE);
  assign mem_addr = xfer ? cur_a[act] : '0;
  assign mem_wr   = xfer && typ == 2'b01;
  assign io_rd    = xfer && typ == 2'b01;
  assign mem_rd   = xfer && typ == 2'b10;
  assign io_wr    = xfer && typ == 2'b10;
  assign tc_end   = xfer && is_tc;

  always_comb begin
    case (reg_addr[3:2])
      2'd0: reg_rdata = cur_a[reg_addr[1:0]];
      2'd1: reg_rdata = cur_c[reg_addr[1:0]];
      2'd2: reg_rdata = W'(mode[reg_addr[1:0]]);
      default: begin
        case (reg_addr[1:0])
          2'd0:    reg_rdata = W'(cmd);
          2'd2:    reg_rdata = W'(mask);
          2'd3:    reg_rdata = W'({req_act, tc_st});
          default: reg_rdata = '0;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      act   <= 2'd0;
      last  <= 2'd3;
      cmd   <= '0;
      mask  <= '1;
      tc_st <= '0;
      for (int i = 0; i < NCH; i++) begin
        base_a[i] <= '0;
        base_c[i] <= '0;
        cur_a[i]  <= '0;
        cur_c[i]  <= '0;
        mode[i]   <= '0;
      end
    end else begin
      if (reg_rd && reg_addr == 4'd15) tc_st <= '0;
      if (reg_wr) begin
        case (reg_addr[3:2])
          2'd0: begin
            base_a[reg_addr[1:0]] <= reg_wdata;
            cur_a[reg_addr[1:0]]  <= reg_wdata;
          end
          2'd1: begin
            base_c[reg_addr[1:0]] <= reg_wdata;
            cur_c[reg_addr[1:0]]  <= reg_wdata;
          end
          2'd2: mode[reg_addr[1:0]] <= reg_wdata[5:0];
          default: begin
            case (reg_addr[1:0])
              2'd0:    cmd <= reg_wdata[3:0];
              2'd1:    mask[reg_wdata[1:0]] <= reg_wdata[2];
              2'd2:    mask <= reg_wdata[3:0];
              default: ;
            endcase
          end
        endcase
      end
      case (st)
        S_IDLE: if (|elig) st <= S_HOLD;
        S_HOLD: begin
          if (!(|elig)) st <= S_IDLE;
          else if (bus_grant) begin
            st  <= S_XFER;
            act <= pick;
          end
        end
        default: begin
          cur_a[act] <= mode[act][3] ? cur_a[act] - W'(1) : cur_a[act] + W'(1);
          cur_c[act] <= cur_c[act] - W'(1);
          if (is_tc) begin
            tc_st[act] <= 1'b1;
            if (mode[act][2]) begin
              cur_a[act] <= base_a[act];
              cur_c[act] <= base_c[act];
            end else begin
              mask[act] <= 1'b1;
            end
          end
          if (!cont) begin
            st   <= S_IDLE;
            last <= act;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dma4_flyby_chk.sv
module dma4_flyby_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ack_hot,
  input logic       bus_req,
  input logic       bus_grant,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       io_rd,
  input logic       io_wr,
  input logic       tc_end
);
  a_r3_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_hot));

  a_r2_grant_before_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|ack_hot) |-> ($past(bus_grant) && bus_req));

  a_r4_strobe_pairing: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd == mem_wr) && (io_wr == mem_rd) && !(mem_rd && mem_wr));

  a_r4_strobe_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (|ack_hot));

  a_r5_tc_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    tc_end |-> (|ack_hot));

  a_r7_tc_ends_tenure: assert property (@(posedge clk) disable iff (!rst_n)
    tc_end |=> (ack_hot == 4'b0000));
endmodule

bind dma4_flyby dma4_flyby_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_hot(ack_hot), .bus_req(bus_req),
  .bus_grant(bus_grant), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .io_rd(io_rd), .io_wr(io_wr), .tc_end(tc_end)
);

// File: tb/dma4_flyby_bench.sv
module dma4_flyby_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  dev_req = '0;
  logic [3:0]  dev_ack;
  logic        bus_req, bus_grant = 1'b0, grant_en = 1'b1;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, io_rd, io_wr, tc_end;

  always #2 clk = ~clk;

  dma4_flyby u_dma4_flyby (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dev_req(dev_req), .dev_ack(dev_ack), .bus_req(bus_req),
    .bus_grant(bus_grant), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .tc_end(tc_end)
  );

  always @(posedge clk) bus_grant <= rst_n && grant_en && bus_req;

  typedef struct {
    int          ch;
    logic [15:0] addr;
    logic [3:0]  str;
    logic        tc;
    string       tag;
  } item_t;

  item_t q[$];
  int errors = 0, checks = 0, seen = 0, rises = 0;
  logic ack_lo = 1'b0, prev_breq = 1'b0;
  logic [3:0] hot;
  logic [15:0] v;

  localparam logic [3:0] S_WR = 4'b0110, S_RD = 4'b1001, S_VF = 4'b0000;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] actual, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, actual, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
    if (a == 4'd12) ack_lo = d[3];
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  task automatic push1(input int ch, input logic [15:0] a, input logic [3:0] s,
                       input logic tc, input string tag);
    item_t e;
    e.ch = ch; e.addr = a; e.str = s; e.tc = tc; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push_run(input int ch, input logic [15:0] base, input int cnt,
                          input bit dec, input logic [3:0] s, input string tag);
    for (int i = 0; i <= cnt; i++)
      push1(ch, dec ? base - 16'(i) : base + 16'(i), s, i == cnt, tag);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    while (bus_req) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      hot = dev_ack ^ {4{ack_lo}};
      if (bus_req && !prev_breq) rises++;
      prev_breq = bus_req;
      if (hot != 4'b0000) begin
        seen++;
        if (q.size() == 0) begin
          chk(1'b0, "R3", "unexpected transfer ack", 32'(hot), 0);
        end else begin
          item_t e;
          e = q.pop_front();
          chk(hot == (4'b0001 << e.ch), e.tag, "channel ack", 32'(hot), 32'(4'b0001 << e.ch));
          chk(mem_addr == e.addr, e.tag, "address", 32'(mem_addr), 32'(e.addr));
          chk({mem_rd, mem_wr, io_rd, io_wr} == e.str, e.tag, "strobes",
              32'({mem_rd, mem_wr, io_rd, io_wr}), 32'(e.str));
          chk(tc_end == e.tc, e.tag, "tc_end", 32'(tc_end), 32'(e.tc));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bus_req == 1'b0, "R1", "bus_req after reset", 32'(bus_req), 0);
    chk(dev_ack == 4'h0, "R1", "dev_ack after reset", 32'(dev_ack), 0);
    rd(4'd14, v); chk(v == 16'h000F, "R1", "mask after reset", 32'(v), 32'hF);
    rd(4'd15, v); chk(v == 16'h0000, "R1", "status after reset", 32'(v), 0);
    rd(4'd12, v); chk(v == 16'h0000, "R1", "command after reset", 32'(v), 0);

    // R13 register window, R2 grant wait, R4 write type, R5 increment, R7 block
    wr(4'd1, 16'h1000); wr(4'd5, 16'd3); wr(4'd9, 16'h0021);
    rd(4'd1, v); chk(v == 16'h1000, "R13", "address readback", 32'(v), 32'h1000);
    rd(4'd5, v); chk(v == 16'd3, "R13", "count readback", 32'(v), 3);
    rd(4'd9, v); chk(v == 16'h0021, "R13", "mode readback", 32'(v), 32'h21);
    grant_en = 1'b0;
    wr(4'd13, 16'h0001);
    s0 = seen; r0 = rises;
    push_run(1, 16'h1000, 3, 1'b0, S_WR, "R4/R5 block write");
    dev_req = 4'b0010;
    repeat (10) @(negedge clk);
    chk(bus_req == 1'b1, "R2", "bus_req held while grant withheld", 32'(bus_req), 1);
    chk(seen == s0, "R2", "transfers before grant", 32'(seen - s0), 0);
    grant_en = 1'b1;
    drain();
    dev_req = 4'b0000;
    chk(rises - r0 == 1, "R7", "block bus tenures", 32'(rises - r0), 1);
    rd(4'd15, v); chk(v == 16'h0002, "R6", "status tc ch1", 32'(v), 32'h2);
    rd(4'd15, v); chk(v == 16'h0000, "R12", "status cleared by read", 32'(v), 0);
    rd(4'd14, v); chk(v == 16'h000F, "R6", "mask set at tc", 32'(v), 32'hF);
    rd(4'd1, v); chk(v == 16'h1004, "R5", "address after run", 32'(v), 32'h1004);
    rd(4'd5, v); chk(v == 16'hFFFF, "R5", "count rolled past zero", 32'(v), 32'hFFFF);

    // R4 read type, R5 decrement, R6 auto-initialise
    wr(4'd2, 16'h2000); wr(4'd6, 16'd2); wr(4'd10, 16'h002E);
    wr(4'd13, 16'h0002);
    push_run(2, 16'h2000, 2, 1'b1, S_RD, "R4/R5 block read dec");
    s0 = seen;
    dev_req = 4'b0100;
    wait (seen == s0 + 1);
    dev_req = 4'b0000;
    drain();
    rd(4'd2, v); chk(v == 16'h2000, "R6", "auto-init address reload", 32'(v), 32'h2000);
    rd(4'd6, v); chk(v == 16'd2, "R6", "auto-init count reload", 32'(v), 2);
    rd(4'd14, v); chk(v == 16'h000B, "R6", "auto-init keeps mask", 32'(v), 32'hB);
    rd(4'd15, v); chk(v == 16'h0004, "R6", "status tc ch2", 32'(v), 32'h4);

    // R11 all-mask, R4 verify, R7 demand stop
    wr(4'd14, 16'h000E);
    rd(4'd14, v); chk(v == 16'h000E, "R11", "all-mask write", 32'(v), 32'hE);
    wr(4'd0, 16'h0100); wr(4'd4, 16'd9); wr(4'd8, 16'h0000);
    push_run(0, 16'h0100, 3, 1'b0, S_VF, "R4/R7 demand verify");
    q[$].tc = 1'b0;
    s0 = seen;
    dev_req = 4'b0001;
    wait (seen == s0 + 4);
    dev_req = 4'b0000;
    drain();
    rd(4'd4, v); chk(v == 16'd5, "R7", "demand stopped count", 32'(v), 5);
    rd(4'd0, v); chk(v == 16'h0104, "R7", "demand stopped address", 32'(v), 32'h104);
    rd(4'd15, v); chk(v == 16'h0000, "R7", "no tc after demand stop", 32'(v), 0);

    // R8 fixed priority, R7 single
    wr(4'd0, 16'h0300); wr(4'd4, 16'd1); wr(4'd8, 16'h0011);
    wr(4'd3, 16'h3000); wr(4'd7, 16'd1); wr(4'd11, 16'h0012);
    wr(4'd14, 16'h0006);
    push_run(0, 16'h0300, 1, 1'b0, S_WR, "R8 fixed ch0 first");
    push_run(3, 16'h3000, 1, 1'b0, S_RD, "R8 fixed ch3 second");
    r0 = rises;
    dev_req = 4'b1001;
    drain();
    dev_req = 4'b0000;
    chk(rises - r0 == 4, "R7", "single bus tenures", 32'(rises - r0), 4);
    rd(4'd15, v); chk(v == 16'h0009, "R6", "status tc ch0 ch3", 32'(v), 32'h9);

    // R8 rotating priority
    wr(4'd12, 16'h0002);
    wr(4'd0, 16'h0400); wr(4'd4, 16'd1); wr(4'd8, 16'h0011);
    wr(4'd2, 16'h2400); wr(4'd6, 16'd1); wr(4'd10, 16'h0011);
    wr(4'd14, 16'h000A);
    push1(0, 16'h0400, S_WR, 1'b0, "R8 rotate 1");
    push1(2, 16'h2400, S_WR, 1'b0, "R8 rotate 2");
    push1(0, 16'h0401, S_WR, 1'b1, "R8 rotate 3");
    push1(2, 16'h2401, S_WR, 1'b1, "R8 rotate 4");
    dev_req = 4'b0101;
    drain();
    dev_req = 4'b0000;
    rd(4'd15, v); chk(v == 16'h0005, "R6", "status tc ch0 ch2", 32'(v), 32'h5);

    // R9 polarity, R12 pending bits
    dev_req = 4'hF;
    wr(4'd12, 16'h000C);
    @(negedge clk);
    chk(dev_ack == 4'hF, "R9", "active-low ack idles high", 32'(dev_ack), 32'hF);
    wr(4'd1, 16'h5000); wr(4'd5, 16'd0); wr(4'd9, 16'h0021);
    dev_req = 4'hD;
    rd(4'd15, v); chk(v == 16'h0020, "R12", "pending bit active-low ch1", 32'(v), 32'h20);
    push1(1, 16'h5000, S_WR, 1'b1, "R9 active-low transfer");
    wr(4'd14, 16'h000D);
    drain();
    dev_req = 4'hF;
    rd(4'd15, v); chk(v == 16'h0002, "R9", "status after low-polarity run", 32'(v), 32'h2);

    // R10 disable, R11 single-mask and masked channel ignored
    wr(4'd12, 16'h0001);
    dev_req = 4'h0;
    wr(4'd3, 16'h6000); wr(4'd7, 16'd0); wr(4'd11, 16'h0020);
    wr(4'd13, 16'h0003);
    rd(4'd14, v); chk(v == 16'h0007, "R11", "single-mask clear ch3", 32'(v), 32'h7);
    s0 = seen;
    dev_req = 4'h8;
    repeat (10) @(negedge clk);
    chk(bus_req == 1'b0, "R10", "disabled raises no bus_req", 32'(bus_req), 0);
    chk(seen == s0, "R10", "disabled makes no transfer", 32'(seen - s0), 0);
    push1(3, 16'h6000, S_VF, 1'b1, "R10 after enable");
    wr(4'd12, 16'h0000);
    drain();
    rd(4'd15, v); chk(v == 16'h0088, "R12", "status tc ch3 and pending ch3", 32'(v), 32'h88);
    s0 = seen;
    dev_req = 4'hF;
    repeat (10) @(negedge clk);
    chk(bus_req == 1'b0, "R11", "masked channels raise no bus_req", 32'(bus_req), 0);
    chk(seen == s0, "R11", "masked channels not serviced", 32'(seen - s0), 0);
    dev_req = 4'h0;
    chk(q.size() == 0, "R3", "scoreboard empty at end", 32'(q.size()), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule